// File: doc/BRIEF.md
# PHY Duplex and Collision-Test Control

This block keeps the duplex and collision-test control bits of a PHY's basic control register, together with the loopback and auto-negotiation enable bits that they depend on. A management agent writes these bits through a simple strobe port and reads them back. The block works out which duplex mode is in effect from a strapping input, a duplex pin, the auto-negotiation enable bit, the negotiated result and the loopback bit. It drives a registered status output that shows the duplex of the active link.

When collision test is enabled, the block drives the MII collision output so that it echoes transmit enable. A single-cycle bit-time enable paces the delays. The collision output rises a configurable number of bit times after transmit enable goes high. It falls two bit times after transmit enable goes low.

Top module: `phy_dpx_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `mgmt_rdata` reads 0, `col` is 0 and `link_full` is 0.
- R2: On a clock edge where `mgmt_we` is high, the writable bits are loaded from `mgmt_wdata`: bit 14 is loopback, bit 12 is auto-negotiation enable, bit 8 is duplex (1 = full) and bit 7 is collision test. `mgmt_rdata` shows the stored bits without further delay. With `mgmt_we` low the stored bits hold.
- R3: Every bit of `mgmt_rdata` other than 14, 12, 8 and 7 reads 0, even after all ones are written.
- R4: With `sw_mode` low, `link_full` equals `dpx_pin` one cycle later, whatever the value of the duplex bit.
- R5: With `sw_mode` high and auto-negotiation enabled, `link_full` equals `an_full` one cycle later, whatever the value of the duplex bit.
- R6: With `sw_mode` high, auto-negotiation disabled and loopback clear, `link_full` is 0 when the duplex bit is 0 and 1 when it is 1.
- R7: With `sw_mode` high, auto-negotiation disabled and loopback set, `link_full` is 1 regardless of the duplex bit.
- R8: While collision test is 0, `col` stays 0 whatever `tx_en` does. Clearing collision test forces `col` to 0 within two cycles.
- R9: While collision test is 1, `col` becomes 1 in the cycle after the clock edge that samples the ASSERT_BT-th `bit_en` pulse with `tx_en` high.
- R10: Once `col` is 1, it returns to 0 in the cycle after the edge that samples the second `bit_en` pulse with `tx_en` low. Cycles with `bit_en` low do not count toward this delay.
- R11: Collision test works the same way while loopback is set.
- R12: If `tx_en` falls before `col` has asserted, the assert count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data (combinational) |
| sw_mode | input | 1 | 1 = register controls duplex, 0 = pin controls duplex |
| dpx_pin | input | 1 | Strapped duplex select (1 = full) |
| an_full | input | 1 | Negotiated duplex result (1 = full) |
| bit_en | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | MII transmit enable |
| col | output | 1 | MII collision output |
| link_full | output | 1 | Active-link duplex status (1 = full) |

## Verification
The bench builds the block with ASSERT_BT = 5. With that value the full assert window, the edge on which `col` rises, can be reached within a few cycles and checked exactly. The short window also makes it easy to drop `tx_en` part-way through the count and to check the restart. The deassert delay is exercised both with `bit_en` high every cycle and with gaps in `bit_en`. The duplex chain is checked at every level of priority, each time with the duplex bit set to the value that would give the wrong answer if it were not ignored.

// File: rtl/phy_dpx_pkg.sv
package phy_dpx_pkg;
  localparam int REG_W    = 16;
  localparam int POS_LOOP = 14;
  localparam int POS_ANEN = 12;
  localparam int POS_DPX  = 8;
  localparam int POS_CTST = 7;
  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << POS_LOOP) | (REG_W'(1) << POS_ANEN) |
    (REG_W'(1) << POS_DPX)  | (REG_W'(1) << POS_CTST);

  typedef struct packed {
    logic loop;
    logic anen;
    logic dpx;
    logic ctst;
  } ctl_t;
endpackage

// File: rtl/dpx_ctl_regs.sv
module dpx_ctl_regs
  import phy_dpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ctl_t             ctl
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)     reg_q <= '0;
    else if (we) reg_q <= wdata & WR_MASK;
  end

  assign rdata    = reg_q;
  assign ctl.loop = reg_q[POS_LOOP];
  assign ctl.anen = reg_q[POS_ANEN];
  assign ctl.dpx  = reg_q[POS_DPX];
  assign ctl.ctst = reg_q[POS_CTST];

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~WR_MASK) == '0);
  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));
  assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == ($past(wdata) & WR_MASK));
endmodule

// File: rtl/dpx_resolve.sv
module dpx_resolve
  import phy_dpx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_mode,
  input  logic dpx_pin,
  input  logic an_full,
  input  ctl_t ctl,
  output logic link_full
);
  logic full_d;

  always_comb begin
    if (!sw_mode)      full_d = dpx_pin;
    else if (ctl.anen) full_d = an_full;
    else if (ctl.loop) full_d = 1'b1;
    else               full_d = ctl.dpx;
  end

  always_ff @(posedge clk) begin
    if (rst) link_full <= 1'b0;
    else     link_full <= full_d;
  end

  assert_pin_mode_R4: assert property (@(posedge clk) disable iff (rst)
    !sw_mode |=> link_full == $past(dpx_pin));
  assert_an_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_mode && ctl.anen) |=> link_full == $past(an_full));
  assert_loop_full_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_mode && !ctl.anen && ctl.loop) |=> link_full);
endmodule

// File: rtl/col_test_gen.sv
module col_test_gen #(
  parameter int ASSERT_BT   = 512,
  parameter int DEASSERT_BT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_en,
  input  logic tx_en,
  output logic col
);
  localparam int MAXC = (ASSERT_BT > DEASSERT_BT) ? ASSERT_BT : DEASSERT_BT;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      col <= 1'b0;
      cnt <= '0;
    end else if (tx_en && !col) begin
      if (bit_en) begin
        if (cnt == CW'(ASSERT_BT - 1)) begin
          col <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (!tx_en && col) begin
      if (bit_en) begin
        if (cnt == CW'(DEASSERT_BT - 1)) begin
          col <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      cnt <= '0;
    end
  end

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !col);
  assert_rise_on_tx_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(col) |-> ($past(tx_en) && $past(bit_en)));
  assert_fall_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(col) |-> ((!$past(tx_en) && $past(bit_en)) || !$past(enable)));
endmodule

// File: rtl/phy_dpx_ctl.sv
module phy_dpx_ctl
  import phy_dpx_pkg::*;
#(
  parameter int ASSERT_BT = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mgmt_we,
  input  logic [REG_W-1:0] mgmt_wdata,
  output logic [REG_W-1:0] mgmt_rdata,
  input  logic             sw_mode,
  input  logic             dpx_pin,
  input  logic             an_full,
  input  logic             bit_en,
  input  logic             tx_en,
  output logic             col,
  output logic             link_full
);
  ctl_t ctl;

  dpx_ctl_regs u_regs (
    .clk(clk), .rst(rst), .we(mgmt_we), .wdata(mgmt_wdata),
    .rdata(mgmt_rdata), .ctl(ctl)
  );

  dpx_resolve u_res (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .dpx_pin(dpx_pin),
    .an_full(an_full), .ctl(ctl), .link_full(link_full)
  );

  col_test_gen #(.ASSERT_BT(ASSERT_BT), .DEASSERT_BT(2)) u_col (
    .clk(clk), .rst(rst), .enable(ctl.ctst), .bit_en(bit_en),
    .tx_en(tx_en), .col(col)
  );
endmodule

// File: tb/phy_dpx_ctl_tb_top.sv
module phy_dpx_ctl_tb_top;
  localparam int ABT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mgmt_we = 1'b0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic sw_mode = 1'b0, dpx_pin = 1'b0, an_full = 1'b0;
  logic bit_en = 1'b0, tx_en = 1'b0;
  logic col, link_full;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] val;
  } exp_t;
  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phy_dpx_ctl #(.ASSERT_BT(ABT)) dut_i (
    .clk(clk), .rst(rst), .mgmt_we(mgmt_we), .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata), .sw_mode(sw_mode), .dpx_pin(dpx_pin),
    .an_full(an_full), .bit_en(bit_en), .tx_en(tx_en), .col(col),
    .link_full(link_full)
  );

  // monitor: compares queued expectations 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] got;
      e = q.pop_front();
      case (e.sel)
        0:       got = mgmt_rdata;
        1:       got = {15'd0, col};
        default: got = {15'd0, link_full};
      endcase
      n_chk++;
      if (got !== e.val) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, got, e.val);
      end
    end
  end

  task automatic push(string req, int sel, logic [15:0] v);
    exp_t e;
    e.req = req; e.sel = sel; e.val = v;
    q.push_back(e);
  endtask

  task automatic wr(string req, logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_wdata = d;
    push(req, 0, d & 16'h5180);
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic chk_link(string req, logic s, logic p, logic a, logic v);
    sw_mode = s; dpx_pin = p; an_full = a;
    push(req, 2, {15'd0, v});
    @(negedge clk);
  endtask

  task automatic col_step(string req, logic t, logic b, logic v);
    tx_en = t; bit_en = b;
    push(req, 1, {15'd0, v});
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    push("R1", 0, 16'h0); push("R1", 1, 16'h0); push("R1", 2, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    push("R1", 0, 16'h0); push("R1", 1, 16'h0);
    @(negedge clk);

    wr("R2_R3", 16'hFFFF);
    wr("R2", 16'h0000);
    wr("R3", 16'hAE7F);
    push("R2", 0, 16'h0000);
    @(negedge clk);

    // pin mode ignores duplex bit (bit8 = 1 here)
    wr("R2", 16'h0100);
    chk_link("R4", 1'b0, 1'b0, 1'b1, 1'b0);
    chk_link("R4", 1'b0, 1'b1, 1'b0, 1'b1);
    // auto-negotiation mode, duplex bit 1 then 0
    wr("R2", 16'h1100);
    chk_link("R5", 1'b1, 1'b1, 1'b0, 1'b0);
    wr("R2", 16'h1000);
    chk_link("R5", 1'b1, 1'b0, 1'b1, 1'b1);
    // register bit decides
    wr("R2", 16'h0000);
    chk_link("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    wr("R2", 16'h0100);
    chk_link("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    // loopback forces full
    wr("R2", 16'h4000);
    chk_link("R7", 1'b1, 1'b0, 1'b0, 1'b1);

    // collision test off
    wr("R2", 16'h0000);
    for (int i = 0; i < 8; i++) col_step("R8", 1'b1, 1'b1, 1'b0);
    col_step("R8", 1'b0, 1'b0, 1'b0);

    // collision test on
    wr("R2", 16'h0080);
    for (int k = 1; k <= ABT; k++) col_step("R9", 1'b1, 1'b1, (k == ABT));
    col_step("R9", 1'b1, 1'b1, 1'b1);
    col_step("R10", 1'b0, 1'b0, 1'b1);
    col_step("R10", 1'b0, 1'b1, 1'b1);
    col_step("R10", 1'b0, 1'b0, 1'b1);
    col_step("R10", 1'b0, 1'b1, 1'b0);

    // restart on early drop
    for (int k = 0; k < 3; k++) col_step("R12", 1'b1, 1'b1, 1'b0);
    col_step("R12", 1'b0, 1'b1, 1'b0);
    for (int k = 1; k <= ABT; k++) col_step("R12", 1'b1, 1'b1, (k == ABT));

    // disabling collision test clears col
    wr("R8", 16'h0000);
    col_step("R8", 1'b1, 1'b1, 1'b0);

    // with loopback
    col_step("R11", 1'b0, 1'b0, 1'b0);
    wr("R11", 16'h4080);
    for (int k = 1; k <= ABT; k++) col_step("R11", 1'b1, 1'b1, (k == ABT));
    col_step("R11", 1'b0, 1'b1, 1'b1);
    col_step("R11", 1'b0, 1'b1, 1'b0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule